// File: doc/BRIEF.md
# Interleaved DAC/ADC Serial Packet Engine

This block is the controller end of a single-wire-each-way serial link to a remote board. Once the system run signal is HIGH it drives a serial clock and sends a DAC command packet on every 16 bit periods, back to back. Each packet carries a converter select, an 8-bit DAC code and three power-shutdown controls. Over the same link it receives a longer, 50-bit status packet. That packet carries two 3-bit ADC selects and two 12-bit ADC results, bit-interleaved with converter B ahead of converter A. It also holds a HIGH-HIGH framing marker and a trailing power-good bit.

Each bit period lasts two cycles of the block clock. The serial clock is LOW in the first cycle and HIGH in the second. Outgoing bits change when the serial clock falls. Incoming bits are taken when it rises. The outgoing fields are captured once per packet. A received packet is committed to the parallel outputs with a one-cycle valid pulse, but only when its framing marker was correct. Otherwise the packet produces a one-cycle framing-error pulse and the outputs keep their old values.

Top module: `sdx_engine`

## Requirements
- R1: While `sys_run` is LOW (or `rst` is HIGH), `ser_out` and `ser_clk` are LOW and both bit counters restart. Bit 0 of both packets is presented from the clock edge that first sees `sys_run` HIGH.
- R2: Each bit period is two clock cycles, first with `ser_clk` LOW and then with it HIGH. `ser_out` keeps its value across the whole period. `ser_in` is sampled at the edge where `ser_clk` rises.
- R3: Outgoing packets are 16 bits, sent with no gaps. Bits 0-2 are `dac_sel` MSB first. Bit 3 is LOW. Bits 4-11 are `dac_data` MSB first. Bits 12-14 are `pwr_shdn` MSB first. Bit 15 is LOW.
- R4: `dac_sel`, `dac_data` and `pwr_shdn` are captured only when a packet starts. A change during a packet first appears in the next packet.
- R5: Incoming bits 0-5 carry the two selects interleaved as B[2], A[2], B[1], A[1], B[0], A[0].
- R6: Incoming bits 20-43 carry the two 12-bit results interleaved, MSB first, B before A: B[11], A[11], ..., B[0], A[0].
- R7: The incoming packet is 50 bits long, and its bit 49 is the power-good status. Its bit 0 coincides with bit 0 of the first outgoing packet after the run starts, and it repeats with no gap.
- R8: If incoming bits 16 and 17 were both HIGH, all five result outputs are updated in the cycle after bit 49 is sampled, and `res_valid` is HIGH for exactly that one cycle.
- R9: If either marker bit was LOW, `frame_err` pulses for one cycle instead, `res_valid` stays LOW, and the result outputs keep their previous values.
- R10: The values of incoming bits 6-15, 18, 19 and 44-48 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, two cycles per serial bit |
| rst | input | 1 | Synchronous active-high reset |
| sys_run | input | 1 | HIGH enables streaming; LOW holds the link idle |
| dac_sel | input | 3 | DAC select for outgoing packets |
| dac_data | input | 8 | DAC code for outgoing packets |
| pwr_shdn | input | 3 | Power-shutdown controls for outgoing packets |
| ser_clk | output | 1 | Serial clock to the remote board |
| ser_out | output | 1 | Serial data to the remote board |
| ser_in | input | 1 | Serial data from the remote board |
| adc_sel_a | output | 3 | Committed select of converter A |
| adc_sel_b | output | 3 | Committed select of converter B |
| adc_res_a | output | 12 | Committed result of converter A |
| adc_res_b | output | 12 | Committed result of converter B |
| pgood | output | 1 | Committed power-good status |
| res_valid | output | 1 | One-cycle pulse when results are committed |
| frame_err | output | 1 | One-cycle pulse when a packet had a bad marker |

## Verification
Serial bit n occupies clock cycles 2n+1 and 2n+2 after the edge that sees `sys_run` HIGH. The bench therefore checks each outgoing bit at both falling clock edges of its period, and it changes `ser_in` only at the first one. The parallel results and `res_valid` or `frame_err` appear one cycle after bit 49 is sampled. That is the second half of bit 49's period, so the bench compares them there. It also confirms that `res_valid` is LOW one period earlier. The expected DAC word for each packet is fixed at that packet's first bit, from the inputs as they stood then.

// File: rtl/sdx_pkg.sv
package sdx_pkg;

    localparam int SEL_W     = 3;
    localparam int DAC_W     = 8;
    localparam int SHDN_W    = 3;
    localparam int ADC_W     = 12;
    localparam int TX_LEN    = SEL_W + 1 + DAC_W + SHDN_W + 1;
    localparam int RX_LEN    = 50;
    localparam int TX_IDX_W  = $clog2(TX_LEN);
    localparam int RX_IDX_W  = $clog2(RX_LEN);
    localparam int SEL_IW    = $clog2(SEL_W);
    localparam int RES_IW    = $clog2(ADC_W);

    // incoming slot map
    localparam int SEL_LAST  = 2 * SEL_W - 1;
    localparam int MARK_0    = 16;
    localparam int MARK_1    = 17;
    localparam int RES_FIRST = 20;
    localparam int RES_LAST  = RES_FIRST + 2 * ADC_W - 1;
    localparam int PG_SLOT   = RX_LEN - 1;

    typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [DAC_W-1:0]  data;
        logic [SHDN_W-1:0] shdn;
    } tx_fields_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel_a;
        logic [SEL_W-1:0] sel_b;
        logic [ADC_W-1:0] res_a;
        logic [ADC_W-1:0] res_b;
        logic             pgood;
    } rx_result_t;

    // outgoing word, bit TX_LEN-1 is sent first
    function automatic logic [TX_LEN-1:0] pack_tx(input tx_fields_t f);
        return {f.sel, 1'b0, f.data, f.shdn, 1'b0};
    endfunction

endpackage

// File: rtl/sdx_bit_timer.sv
module sdx_bit_timer
    import sdx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    output logic                active,
    output logic                ser_clk,
    output logic [TX_IDX_W-1:0] tx_idx,
    output logic [RX_IDX_W-1:0] rx_idx,
    output logic                sample_en,
    output logic                load_en
);
    phase_e phase;
    logic   advance_en;
    logic   tx_wrap;
    logic   rx_wrap;

    assign tx_wrap    = (tx_idx == TX_IDX_W'(TX_LEN - 1));
    assign rx_wrap    = (rx_idx == RX_IDX_W'(RX_LEN - 1));
    assign sample_en  = active && (phase == PH_LOW);
    assign advance_en = active && (phase == PH_HIGH);
    assign ser_clk    = (phase == PH_HIGH);
    assign load_en    = run && !rst && (!active || (advance_en && tx_wrap));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            active <= 1'b0;
            phase  <= PH_LOW;
            tx_idx <= '0;
            rx_idx <= '0;
        end else if (!active) begin
            active <= 1'b1;
        end else if (phase == PH_LOW) begin
            phase <= PH_HIGH;
        end else begin
            phase  <= PH_LOW;
            tx_idx <= tx_wrap ? '0 : tx_idx + 1'b1;
            rx_idx <= rx_wrap ? '0 : rx_idx + 1'b1;
        end
    end
endmodule

// File: rtl/sdx_tx.sv
module sdx_tx
    import sdx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load_en,
    input  logic                active,
    input  logic [TX_IDX_W-1:0] tx_idx,
    input  tx_fields_t          fields,
    output logic                ser_out
);
    logic [TX_LEN-1:0]   word_q;
    logic [TX_IDX_W-1:0] bit_pos;

    assign bit_pos = TX_IDX_W'(TX_LEN - 1) - tx_idx;
    assign ser_out = active && word_q[bit_pos];

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (load_en) begin
            word_q <= pack_tx(fields);
        end
    end
endmodule

// File: rtl/sdx_rx.sv
module sdx_rx
    import sdx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_en,
    input  logic [RX_IDX_W-1:0] rx_idx,
    input  logic                ser_in,
    output rx_result_t          result,
    output logic                res_valid,
    output logic                frame_err
);
    rx_result_t          shadow;
    logic                marker_ok;
    logic [RX_IDX_W-1:0] res_off;
    logic [SEL_IW-1:0]   sel_pos;
    logic [RES_IW-1:0]   res_pos;
    logic                in_sel;
    logic                in_res;

    assign in_sel  = (rx_idx <= RX_IDX_W'(SEL_LAST));
    assign in_res  = (rx_idx >= RX_IDX_W'(RES_FIRST)) && (rx_idx <= RX_IDX_W'(RES_LAST));
    assign res_off = rx_idx - RX_IDX_W'(RES_FIRST);
    assign sel_pos = SEL_IW'(SEL_W - 1) - SEL_IW'(rx_idx >> 1);
    assign res_pos = RES_IW'(ADC_W - 1) - RES_IW'(res_off >> 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow    <= '0;
            result    <= '0;
            marker_ok <= 1'b0;
            res_valid <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            frame_err <= 1'b0;
            if (sample_en) begin
                if (in_sel) begin
                    if (rx_idx[0]) shadow.sel_a[sel_pos] <= ser_in;
                    else           shadow.sel_b[sel_pos] <= ser_in;
                end
                if (in_res) begin
                    if (res_off[0]) shadow.res_a[res_pos] <= ser_in;
                    else            shadow.res_b[res_pos] <= ser_in;
                end
                if (rx_idx == RX_IDX_W'(MARK_0)) marker_ok <= ser_in;
                if (rx_idx == RX_IDX_W'(MARK_1)) marker_ok <= marker_ok & ser_in;
                if (rx_idx == RX_IDX_W'(PG_SLOT)) begin
                    if (marker_ok) begin
                        result.sel_a <= shadow.sel_a;
                        result.sel_b <= shadow.sel_b;
                        result.res_a <= shadow.res_a;
                        result.res_b <= shadow.res_b;
                        result.pgood <= ser_in;
                        res_valid    <= 1'b1;
                    end else begin
                        frame_err    <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sdx_engine.sv
module sdx_engine
    import sdx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sys_run,
    input  logic [SEL_W-1:0]  dac_sel,
    input  logic [DAC_W-1:0]  dac_data,
    input  logic [SHDN_W-1:0] pwr_shdn,
    output logic              ser_clk,
    output logic              ser_out,
    input  logic              ser_in,
    output logic [SEL_W-1:0]  adc_sel_a,
    output logic [SEL_W-1:0]  adc_sel_b,
    output logic [ADC_W-1:0]  adc_res_a,
    output logic [ADC_W-1:0]  adc_res_b,
    output logic              pgood,
    output logic              res_valid,
    output logic              frame_err
);
    logic                active;
    logic [TX_IDX_W-1:0] tx_idx;
    logic [RX_IDX_W-1:0] rx_idx;
    logic                sample_en;
    logic                load_en;
    tx_fields_t          fields;
    rx_result_t          result;

    assign fields.sel  = dac_sel;
    assign fields.data = dac_data;
    assign fields.shdn = pwr_shdn;

    sdx_bit_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (sys_run),
        .active    (active),
        .ser_clk   (ser_clk),
        .tx_idx    (tx_idx),
        .rx_idx    (rx_idx),
        .sample_en (sample_en),
        .load_en   (load_en)
    );

    sdx_tx u_tx (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .active  (active),
        .tx_idx  (tx_idx),
        .fields  (fields),
        .ser_out (ser_out)
    );

    sdx_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .rx_idx    (rx_idx),
        .ser_in    (ser_in),
        .result    (result),
        .res_valid (res_valid),
        .frame_err (frame_err)
    );

    assign adc_sel_a = result.sel_a;
    assign adc_sel_b = result.sel_b;
    assign adc_res_a = result.res_a;
    assign adc_res_b = result.res_b;
    assign pgood     = result.pgood;
endmodule

// File: rtl/sdx_engine_chk.sv
module sdx_engine_chk
    import sdx_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                sys_run,
    input logic                ser_clk,
    input logic                ser_out,
    input logic [TX_IDX_W-1:0] tx_idx,
    input logic [SEL_W-1:0]    adc_sel_a,
    input logic [SEL_W-1:0]    adc_sel_b,
    input logic [ADC_W-1:0]    adc_res_a,
    input logic [ADC_W-1:0]    adc_res_b,
    input logic                pgood,
    input logic                res_valid,
    input logic                frame_err
);
    p_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
        !sys_run |=> (!ser_out && !ser_clk));

    p_clk_alternates_r2: assert property (@(posedge clk) disable iff (rst)
        ser_clk |=> !ser_clk);

    p_out_held_high_phase_r2: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> $stable(ser_out));

    p_low_slots_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_idx == TX_IDX_W'(3) || tx_idx == TX_IDX_W'(TX_LEN - 1)) |-> !ser_out);

    p_valid_single_r8: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    p_err_excl_valid_r9: assert property (@(posedge clk) disable iff (rst)
        !(res_valid && frame_err));

    p_hold_without_valid_r9: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> $stable({adc_sel_a, adc_sel_b, adc_res_a, adc_res_b, pgood}));
endmodule

bind sdx_engine sdx_engine_chk i_sdx_engine_chk (
    .clk       (clk),
    .rst       (rst),
    .sys_run   (sys_run),
    .ser_clk   (ser_clk),
    .ser_out   (ser_out),
    .tx_idx    (tx_idx),
    .adc_sel_a (adc_sel_a),
    .adc_sel_b (adc_sel_b),
    .adc_res_a (adc_res_a),
    .adc_res_b (adc_res_b),
    .pgood     (pgood),
    .res_valid (res_valid),
    .frame_err (frame_err)
);

// File: tb/test_sdx_engine.sv
module test_sdx_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sys_run = 1'b0;
    logic [2:0]  dac_sel = 3'd0;
    logic [7:0]  dac_data = 8'd0;
    logic [2:0]  pwr_shdn = 3'd0;
    logic        ser_in = 1'b0;
    logic        ser_clk, ser_out, pgood, res_valid, frame_err;
    logic [2:0]  adc_sel_a, adc_sel_b;
    logic [11:0] adc_res_a, adc_res_b;

    int n_chk = 0;
    int n_err = 0;
    int gbit = 0;
    bit chg_en = 1'b0;
    logic [15:0] cur_word;
    logic [2:0]  e_sa = 3'd0, e_sb = 3'd0;
    logic [11:0] e_ra = 12'd0, e_rb = 12'd0;
    logic        e_pg = 1'b0;

    always #5 clk = ~clk;

    sdx_engine i_sdx_engine (
        .clk(clk), .rst(rst), .sys_run(sys_run),
        .dac_sel(dac_sel), .dac_data(dac_data), .pwr_shdn(pwr_shdn),
        .ser_clk(ser_clk), .ser_out(ser_out), .ser_in(ser_in),
        .adc_sel_a(adc_sel_a), .adc_sel_b(adc_sel_b),
        .adc_res_a(adc_res_a), .adc_res_b(adc_res_b),
        .pgood(pgood), .res_valid(res_valid), .frame_err(frame_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] tx_word(input logic [2:0] s, input logic [7:0] d, input logic [2:0] p);
        return {s, 1'b0, d, p, 1'b0};
    endfunction

    function automatic logic fbit(input int i, input logic [2:0] sa, input logic [2:0] sb,
                                  input logic [11:0] ra, input logic [11:0] rb,
                                  input logic pg, input logic [1:0] mk);
        if (i < 6)        return (i % 2 == 0) ? sb[2 - i/2] : sa[2 - i/2];
        if (i == 16)      return mk[1];
        if (i == 17)      return mk[0];
        if (i >= 20 && i <= 43) return ((i - 20) % 2 == 0) ? rb[11 - (i-20)/2] : ra[11 - (i-20)/2];
        if (i == 49)      return pg;
        return 1'($urandom % 2);   // don't-care slot: random garbage (R10)
    endfunction

    task automatic do_bit(input logic inb);
        logic held;
        @(negedge clk);
        if (gbit % 16 == 0) cur_word = tx_word(dac_sel, dac_data, pwr_shdn);
        ser_in = inb;
        chk(ser_clk == 1'b0, "R2 ser_clk low half", 32'(ser_clk), 32'd0);
        chk(ser_out == cur_word[15 - gbit % 16], "R3/R4 outgoing bit",
            32'(ser_out), 32'(cur_word[15 - gbit % 16]));
        held = ser_out;
        if (chg_en && gbit % 16 == 5) begin   // mid-packet change, takes effect next packet (R4)
            dac_sel  = 3'($urandom);
            dac_data = 8'($urandom);
            pwr_shdn = 3'($urandom);
        end
        @(negedge clk);
        chk(ser_clk == 1'b1, "R2 ser_clk high half", 32'(ser_clk), 32'd1);
        chk(ser_out == held, "R2 bit held over period", 32'(ser_out), 32'(held));
        gbit++;
    endtask

    task automatic do_frame(input logic [2:0] sa, input logic [2:0] sb,
                            input logic [11:0] ra, input logic [11:0] rb,
                            input logic pg, input logic [1:0] mk);
        for (int i = 0; i < 50; i++) begin
            do_bit(fbit(i, sa, sb, ra, rb, pg, mk));
            if (i == 48) begin
                chk(res_valid == 1'b0, "R8 no early valid", 32'(res_valid), 32'd0);
                chk(frame_err == 1'b0, "R9 no early error", 32'(frame_err), 32'd0);
            end
        end
        if (mk == 2'b11) begin
            e_sa = sa; e_sb = sb; e_ra = ra; e_rb = rb; e_pg = pg;
            chk(res_valid == 1'b1, "R8 valid pulse", 32'(res_valid), 32'd1);
            chk(frame_err == 1'b0, "R8 no error", 32'(frame_err), 32'd0);
        end else begin
            chk(res_valid == 1'b0, "R9 no valid on bad marker", 32'(res_valid), 32'd0);
            chk(frame_err == 1'b1, "R9 error pulse", 32'(frame_err), 32'd1);
        end
        chk(adc_sel_a == e_sa, "R5 select A", 32'(adc_sel_a), 32'(e_sa));
        chk(adc_sel_b == e_sb, "R5 select B", 32'(adc_sel_b), 32'(e_sb));
        chk(adc_res_a == e_ra, "R6/R10 result A", 32'(adc_res_a), 32'(e_ra));
        chk(adc_res_b == e_rb, "R6/R10 result B", 32'(adc_res_b), 32'(e_rb));
        chk(pgood == e_pg, "R7 power good", 32'(pgood), 32'(e_pg));
        @(negedge clk);
        chk(res_valid == 1'b0 && frame_err == 1'b0, "R8 pulse is one cycle",
            32'({res_valid, frame_err}), 32'd0);
        gbit++;
        // that extra negedge was the first half of the next bit: restart cleanly
    endtask

    task automatic idle_check(input string tag);
        chk(ser_out == 1'b0, tag, 32'(ser_out), 32'd0);
        chk(ser_clk == 1'b0, tag, 32'(ser_clk), 32'd0);
    endtask

    task automatic restart_run();
        sys_run = 1'b0;
        @(negedge clk);
        idle_check("R1 idle after run drop");
        repeat (3) @(negedge clk);
        idle_check("R1 idle held");
        sys_run = 1'b1;
        gbit = 0;
    endtask

    initial begin
        #(10 * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        idle_check("R1 reset state");
        chk({adc_sel_a, adc_sel_b, adc_res_a, adc_res_b, pgood, res_valid, frame_err} == '0,
            "R8 reset outputs", 32'(adc_res_a), 32'd0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        idle_check("R1 idle before run");

        dac_sel = 3'b101; dac_data = 8'hA5; pwr_shdn = 3'b011;
        sys_run = 1'b1;
        gbit = 0;
        // directed: extremes, then the two bad-marker shapes (R9)
        do_frame(3'b111, 3'b000, 12'hFFF, 12'h000, 1'b1, 2'b11);
        restart_run();
        do_frame(3'b010, 3'b101, 12'h5A3, 12'hC3C, 1'b0, 2'b10);
        restart_run();
        do_frame(3'b001, 3'b110, 12'h001, 12'h800, 1'b1, 2'b01);
        restart_run();
        do_frame(3'b000, 3'b111, 12'h000, 12'hFFF, 1'b0, 2'b11);
        // random frames with mid-packet DAC input changes (R4, R10)
        chg_en = 1'b1;
        for (int f = 0; f < 6; f++) begin
            restart_run();
            do_frame(3'($urandom), 3'($urandom), 12'($urandom), 12'($urandom),
                     1'($urandom), 2'b11);
        end
        chg_en = 1'b0;
        restart_run();
        do_frame(3'b100, 3'b011, 12'h9E1, 12'h27B, 1'b1, 2'b00);
        sys_run = 1'b0;
        @(negedge clk);
        idle_check("R1 final idle");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule